// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

The block moves a system clock from an internal RC oscillator over to a primary oscillator (whose output may pass through a PLL), without stopping execution. When software selects the primary source, the core and peripherals keep running from the internal RC clock. Meanwhile a start-up timer counts primary oscillator cycles and, if the PLL is in use, a lock-delay counter runs after it. Only then is the output clock handed over. The handover uses a pair of gates, each switched on the falling edge of its own clock, so the output clock never glitches.

When the handover completes, the block sets a start-up-done flag and clears an internal-stable flag. A request that is withdrawn before completion is abandoned. Selecting the internal source again while running from the primary source hands the clock back the same way. A run enable for the internal oscillator tells the analog block whether the RC source may stop. It may stop only while the primary source drives the system and neither the watchdog nor the fail-safe monitor needs it.

Top module: `clk_src_switch`

## Requirements
- R1: While a switch to the primary source is pending (srcSel = 2'b00 before completion), sysClk follows intClk and oscDone stays 0.
- R2: With pllEn = 0, oscDone rises no earlier than OST_CYCLES (1024 by default) priClk rising edges after srcSel changes to 2'b00, and no more than 80 priClk edges beyond that.
- R3: With pllEn = 1, oscDone rises no earlier than OST_CYCLES + PLL_LOCK_CYCLES priClk rising edges after the request, and no more than 80 priClk edges beyond that.
- R4: On the intClk edge where oscDone rises, intStableFlag becomes 0, even if it was 1 before.
- R5: After the handover, sysClk follows priClk. No high or low pulse of sysClk is shorter than the shorter half-period of the two source clocks.
- R6: intOscRun is 1 whenever the system does not run from the primary source. While it does, intOscRun equals wdtEn OR fscmEn, combinationally.
- R7: While the system runs from the internal source, intStableFlag takes the value of intStable AND (intFreqSel != 0 OR intSrcSel) at the next intClk rising edge.
- R8: If srcSel leaves 2'b00 before the switch completes, the switch is abandoned: oscDone stays 0, sysClk stays on intClk, and a later request again waits the full start-up count.
- R9: While rstN is low, oscDone and intStableFlag are 0, intOscRun is 1, and after release sysClk follows intClk.
- R10: With the system on the primary source, any srcSel other than 2'b00 hands sysClk back to intClk and clears oscDone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| intClk | input | 1 | Internal RC oscillator clock |
| priClk | input | 1 | Primary oscillator clock (after the optional PLL) |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 2 | Clock source select: 2'b00 primary, any other value internal |
| intFreqSel | input | 3 | Internal oscillator frequency select |
| intSrcSel | input | 1 | Internal low-frequency source select |
| intStable | input | 1 | Internal oscillator reports a stable output |
| pllEn | input | 1 | PLL in use: adds the lock delay |
| wdtEn | input | 1 | Watchdog enabled |
| fscmEn | input | 1 | Fail-safe clock monitor enabled |
| sysClk | output | 1 | Glitch-free selected system clock |
| oscDone | output | 1 | Primary source start-up complete and in use |
| intStableFlag | output | 1 | Internal-oscillator-stable flag |
| intOscRun | output | 1 | Keep the internal RC oscillator running |

## Verification
intStableFlag is registered, so the bench drives its inputs on a falling intClk edge and samples on the next falling edge, one rising edge later. intOscRun is combinational and is sampled one time unit after its inputs change. The switch crosses both clock domains, so its completion time is measured in priClk edges from the request and checked against a window: at least the start-up count plus any lock count, with a bounded allowance for synchronizers. Clock-following checks sample sysClk in the middle of the high and low phases of the expected source, and a monitor records the shortest sysClk pulse over the whole run.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_RC   = 3'd0,
    ST_WAIT = 3'd1,
    ST_HAND = 3'd2,
    ST_PRI  = 3'd3,
    ST_BACK = 3'd4
  } swState_t;

  // control to datapath strobes
  typedef struct packed {
    logic startReq;  // run start-up and lock counters
    logic selPri;    // steer the glitch-free mux to the primary clock
  } swStrobe_t;

  localparam logic [1:0] SEL_PRIMARY = 2'b00;

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 80000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic      intClk,
  input  logic      priClk,
  input  logic      rstN,
  input  swStrobe_t strobe,
  input  logic      pllEn,
  output logic      priReady,
  output logic      intGate,
  output logic      priGate,
  output logic      priGateInt,
  output logic      sysClk
);

  localparam int OST_W = $clog2(OST_CYCLES + 1);
  localparam int PLL_W = $clog2(PLL_LOCK_CYCLES + 1);
  localparam logic [OST_W-1:0] OST_LAST = OST_W'(OST_CYCLES);
  localparam logic [PLL_W-1:0] PLL_LAST = PLL_W'(PLL_LOCK_CYCLES);

  // ---------------- primary-domain timers ----------------
  logic reqPri, pllEnPri;
  logic [OST_W-1:0] ostCnt;
  logic [PLL_W-1:0] pllCnt;
  logic ostDone, pllDone;

  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncReq (
    .clk(priClk), .rstN(rstN), .dIn(strobe.startReq), .dOut(reqPri));
  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncPll (
    .clk(priClk), .rstN(rstN), .dIn(pllEn), .dOut(pllEnPri));

  assign ostDone = (ostCnt == OST_LAST);
  assign pllDone = (pllCnt == PLL_LAST);

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN)            ostCnt <= '0;
    else if (!reqPri)     ostCnt <= '0;
    else if (!ostDone)    ostCnt <= ostCnt + 1'b1;
  end

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN)                             pllCnt <= '0;
    else if (!reqPri || !ostDone || !pllEnPri) pllCnt <= '0;
    else if (!pllDone)                     pllCnt <= pllCnt + 1'b1;
  end

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN)        priReady <= 1'b0;
    else if (!reqPri) priReady <= 1'b0;
    else              priReady <= ostDone && (!pllEnPri || pllDone);
  end

  // R3: lock delay follows the start-up count when the PLL is used
  p_pll_wait_r3: assert property (@(posedge priClk) disable iff (!rstN)
    (pllEnPri && $rose(ostDone)) |=> !priReady)
    else $error("lock delay skipped");

  // ---------------- glitch-free clock mux ----------------
  logic intGatePri, selPriPri;
  logic intStage, priStage;

  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncPriGate (
    .clk(intClk), .rstN(rstN), .dIn(priGate), .dOut(priGateInt));
  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncIntGate (
    .clk(priClk), .rstN(rstN), .dIn(intGate), .dOut(intGatePri));
  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncSel (
    .clk(priClk), .rstN(rstN), .dIn(strobe.selPri), .dOut(selPriPri));

  always_ff @(posedge intClk or negedge rstN) begin
    if (!rstN) intStage <= 1'b1;
    else       intStage <= !strobe.selPri && !priGateInt;
  end

  always_ff @(negedge intClk or negedge rstN) begin
    if (!rstN) intGate <= 1'b1;
    else       intGate <= intStage;
  end

  always_ff @(posedge priClk or negedge rstN) begin
    if (!rstN) priStage <= 1'b0;
    else       priStage <= selPriPri && !intGatePri;
  end

  always_ff @(negedge priClk or negedge rstN) begin
    if (!rstN) priGate <= 1'b0;
    else       priGate <= priStage;
  end

  assign sysClk = (intClk && intGate) || (priClk && priGate);

  // R5: the two gates are never open together
  always_comb begin
    if (rstN) begin
      p_gate_mutex_r5: assert (!(intGate && priGate))
        else $error("both clock gates open");
    end
  end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       intClk,
  input  logic       rstN,
  input  logic [1:0] srcSel,
  input  logic [2:0] intFreqSel,
  input  logic       intSrcSel,
  input  logic       intStable,
  input  logic       wdtEn,
  input  logic       fscmEn,
  input  logic       priReady,
  input  logic       intGate,
  input  logic       priGateInt,
  output swStrobe_t  strobe,
  output logic       oscDone,
  output logic       intStableFlag,
  output logic       intOscRun
);

  swState_t state, stateNext;
  logic readyInt, wantPri, rcSideNext, stableCond;

  clksw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncReady (
    .clk(intClk), .rstN(rstN), .dIn(priReady), .dOut(readyInt));

  assign wantPri    = (srcSel == SEL_PRIMARY);
  assign stableCond = intStable && ((intFreqSel != 3'd0) || intSrcSel);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RC:   if (wantPri && !readyInt) stateNext = ST_WAIT;
      ST_WAIT: if (!wantPri)             stateNext = ST_RC;
               else if (readyInt)        stateNext = ST_HAND;
      ST_HAND: if (priGateInt && !intGate) stateNext = ST_PRI;
      ST_PRI:  if (!wantPri)             stateNext = ST_BACK;
      ST_BACK: if (intGate)              stateNext = ST_RC;
      default:                           stateNext = ST_RC;
    endcase
  end

  always_ff @(posedge intClk or negedge rstN) begin
    if (!rstN) state <= ST_RC;
    else       state <= stateNext;
  end

  assign strobe.startReq = (state == ST_WAIT) || (state == ST_HAND) || (state == ST_PRI);
  assign strobe.selPri   = (state == ST_HAND) || (state == ST_PRI);

  assign rcSideNext = (stateNext == ST_RC) || (stateNext == ST_WAIT) || (stateNext == ST_HAND);

  always_ff @(posedge intClk or negedge rstN) begin
    if (!rstN) begin
      oscDone       <= 1'b0;
      intStableFlag <= 1'b0;
    end else begin
      if (state == ST_HAND && stateNext == ST_PRI)      oscDone <= 1'b1;
      else if (state == ST_BACK && stateNext == ST_RC)  oscDone <= 1'b0;
      intStableFlag <= rcSideNext && stableCond;
    end
  end

  assign intOscRun = (state != ST_PRI) || wdtEn || fscmEn;

  // R1: a pending switch keeps the internal gate open and no completion
  p_hold_int_r1: assert property (@(posedge intClk) disable iff (!rstN)
    (state == ST_WAIT) |-> (intGate && !oscDone))
    else $error("left internal clock early");

  // R4: completion coincides with a cleared stable flag and closed internal gate
  p_flags_done_r4: assert property (@(posedge intClk) disable iff (!rstN)
    $rose(oscDone) |-> (!intStableFlag && !intGate))
    else $error("completion flags wrong");

  // R8: withdrawn request returns to internal run without completion
  p_abort_r8: assert property (@(posedge intClk) disable iff (!rstN)
    (state == ST_WAIT && !wantPri) |=> (state == ST_RC && !oscDone))
    else $error("abort not honoured");

  // R10: handing back ends with the internal gate open and the done flag cleared
  p_return_r10: assert property (@(posedge intClk) disable iff (!rstN)
    (state == ST_BACK && intGate) |=> !oscDone)
    else $error("return did not clear done");

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES      = 1024,
  parameter int PLL_LOCK_CYCLES = 80000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       intClk,
  input  logic       priClk,
  input  logic       rstN,
  input  logic [1:0] srcSel,
  input  logic [2:0] intFreqSel,
  input  logic       intSrcSel,
  input  logic       intStable,
  input  logic       pllEn,
  input  logic       wdtEn,
  input  logic       fscmEn,
  output logic       sysClk,
  output logic       oscDone,
  output logic       intStableFlag,
  output logic       intOscRun
);

  swStrobe_t strobe;
  logic priReady, intGate, priGate, priGateInt;

  clksw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .intClk(intClk), .rstN(rstN), .srcSel(srcSel), .intFreqSel(intFreqSel),
    .intSrcSel(intSrcSel), .intStable(intStable), .wdtEn(wdtEn), .fscmEn(fscmEn),
    .priReady(priReady), .intGate(intGate), .priGateInt(priGateInt),
    .strobe(strobe), .oscDone(oscDone), .intStableFlag(intStableFlag),
    .intOscRun(intOscRun));

  clksw_datapath #(
    .OST_CYCLES(OST_CYCLES), .PLL_LOCK_CYCLES(PLL_LOCK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .intClk(intClk), .priClk(priClk), .rstN(rstN), .strobe(strobe), .pllEn(pllEn),
    .priReady(priReady), .intGate(intGate), .priGate(priGate),
    .priGateInt(priGateInt), .sysClk(sysClk));

endmodule

// File: tb/clk_src_switch_bench.sv
module clk_src_switch_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PRI_HALF   = 3;
  localparam int OST        = 1024;
  localparam int LOCK       = 200;
  localparam int SLACK      = 80;
  localparam int WATCHDOG   = 100000;

  logic intClk = 1'b0, priClk = 1'b0, rstN = 1'b0;
  logic [1:0] srcSel = 2'b10;
  logic [2:0] intFreqSel = 3'd0;
  logic intSrcSel = 1'b0, intStable = 1'b0, pllEn = 1'b0, wdtEn = 1'b0, fscmEn = 1'b0;
  logic sysClk, oscDone, intStableFlag, intOscRun;

  int checks = 0, errors = 0;
  int priTicks = 0;
  bit finished = 1'b0;
  bit monEn = 1'b0;
  int lastEdge = 0, minPulse = 1000000;

  clk_src_switch #(.OST_CYCLES(OST), .PLL_LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) u_clk_src_switch (
    .intClk(intClk), .priClk(priClk), .rstN(rstN), .srcSel(srcSel),
    .intFreqSel(intFreqSel), .intSrcSel(intSrcSel), .intStable(intStable),
    .pllEn(pllEn), .wdtEn(wdtEn), .fscmEn(fscmEn), .sysClk(sysClk),
    .oscDone(oscDone), .intStableFlag(intStableFlag), .intOscRun(intOscRun));

  initial forever #(CLK_PERIOD/2) intClk = ~intClk;
  initial begin #1; forever #(PRI_HALF) priClk = ~priClk; end
  always @(posedge priClk) priTicks++;

  // shortest sysClk pulse while enabled
  always @(sysClk) begin
    if (monEn) begin
      if ($time - lastEdge < minPulse) minPulse = int'($time - lastEdge);
    end
    lastEdge = int'($time);
  end

  // {intFreqSel[2:0], intSrcSel, intStable, expected flag}
  localparam logic [5:0] STABLE_VEC [8] = '{
    6'b000_0_1_0, 6'b000_1_1_1, 6'b001_0_1_1, 6'b100_0_1_1,
    6'b111_1_0_0, 6'b010_0_0_0, 6'b000_0_0_0, 6'b110_1_1_1 };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic followInt(input string req);
    for (int i = 0; i < 3; i++) begin
      @(posedge intClk); #2;
      chk(sysClk == 1'b1, req, int'(sysClk), 1);
      #5;
      chk(sysClk == 1'b0, req, int'(sysClk), 0);
    end
  endtask

  task automatic followPri(input string req);
    for (int i = 0; i < 3; i++) begin
      @(posedge priClk); #1;
      chk(sysClk == 1'b1, req, int'(sysClk), 1);
      #3;
      chk(sysClk == 1'b0, req, int'(sysClk), 0);
    end
  endtask

  // request primary and return latency in priClk edges
  task automatic switchUp(output int lat);
    int start;
    @(negedge intClk);
    srcSel = 2'b00;
    start = priTicks;
    while (!oscDone && (priTicks - start) < OST + LOCK + 4 * SLACK) @(posedge priClk);
    lat = priTicks - start;
  endtask

  task automatic switchBack();
    @(negedge intClk);
    srcSel = 2'b10;
    for (int i = 0; i < 60 && oscDone; i++) @(negedge intClk);
  endtask

  initial begin
    int lat;
    // R9: reset state
    #23;
    chk(oscDone == 1'b0, "R9 done in reset", int'(oscDone), 0);
    chk(intStableFlag == 1'b0, "R9 flag in reset", int'(intStableFlag), 0);
    chk(intOscRun == 1'b1, "R9 run in reset", int'(intOscRun), 1);
    @(negedge intClk); rstN = 1'b1;
    followInt("R9 sysClk after reset");
    monEn = 1'b1;

    // R7: stable flag table in internal run
    foreach (STABLE_VEC[k]) begin
      @(negedge intClk);
      {intFreqSel, intSrcSel, intStable} = STABLE_VEC[k][5:1];
      @(negedge intClk);
      chk(intStableFlag == STABLE_VEC[k][0], "R7 stable flag", int'(intStableFlag), int'(STABLE_VEC[k][0]));
    end

    // R6: internal run keeps oscillator on
    #1 chk(intOscRun == 1'b1, "R6 run while internal", int'(intOscRun), 1);

    // R8: abandon a pending switch
    @(negedge intClk); srcSel = 2'b00;
    repeat (50) @(negedge intClk);
    srcSel = 2'b11;
    repeat (20) @(negedge intClk);
    chk(oscDone == 1'b0, "R8 done after abort", int'(oscDone), 0);
    followInt("R8 sysClk after abort");

    // R1, R2, R4: full switch without PLL, counter restarted after abort
    @(negedge intClk);
    intFreqSel = 3'd1; intSrcSel = 1'b0; intStable = 1'b1;
    @(negedge intClk);
    chk(intStableFlag == 1'b1, "R4 flag set before switch", int'(intStableFlag), 1);
    fork
      switchUp(lat);
      begin
        repeat (100) @(negedge intClk);
        chk(oscDone == 1'b0, "R1 done while pending", int'(oscDone), 0);
        followInt("R1 sysClk while pending");
      end
    join
    chk(lat >= OST && lat <= OST + SLACK, "R2 start-up latency", lat, OST);
    chk(intStableFlag == 1'b0, "R4 flag cleared at switch", int'(intStableFlag), 0);
    followPri("R5 sysClk on primary");

    // R6: run enable table in primary run
    for (int m = 0; m < 4; m++) begin
      wdtEn = m[0]; fscmEn = m[1];
      #1 chk(intOscRun == (m != 0), "R6 run in primary", int'(intOscRun), int'(m != 0));
    end
    wdtEn = 1'b0; fscmEn = 1'b0;

    // R10: hand back to internal
    switchBack();
    chk(oscDone == 1'b0, "R10 done cleared", int'(oscDone), 0);
    followInt("R10 sysClk back on internal");

    // R3: switch with PLL lock delay
    @(negedge intClk); pllEn = 1'b1;
    repeat (10) @(negedge intClk);
    switchUp(lat);
    chk(lat >= OST + LOCK && lat <= OST + LOCK + SLACK, "R3 lock latency", lat, OST + LOCK);
    followPri("R5 sysClk on primary with PLL");

    // R5: no runt pulse seen
    chk(minPulse >= PRI_HALF, "R5 shortest pulse", minPulse, PRI_HALF);

    // R9: asynchronous reset while on primary
    monEn = 1'b0;
    #2 rstN = 1'b0;
    #1;
    chk(oscDone == 1'b0, "R9 done after async reset", int'(oscDone), 0);
    chk(intOscRun == 1'b1, "R9 run after async reset", int'(intOscRun), 1);
    srcSel = 2'b10;
    @(negedge intClk); rstN = 1'b1;
    followInt("R9 sysClk after async reset");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge intClk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule